// File: doc/BRIEF.md
# Three-wire-plus-output serial word EEPROM model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. A host talks to it over four wires: a select line, a serial clock, a serial data input and a serial data output. All four pins are sampled by the system clock. The serial clock must therefore run several times slower than the system clock. While select is high, every rising serial-clock edge moves one bit. A frame starts with a 1 bit, which is followed by a 2-bit opcode, then the word address with its most significant bit first, and then 16 data bits if the command needs them.

Reads return a 0 bit first and then the addressed word, most significant bit first. Write, erase, erase-all and write-all change the array only when programming has been enabled. They take effect when select falls after a complete frame. After that, an internal timer counts a programmable number of system clocks. If select is raised again while the timer runs, the data output reads 0. It reads 1 once the timer has finished. Frames sent while the timer runs are ignored. The word array is a register file that resets to the erased value.

Top module: `mw_eeprom`

## Requirements
- R1: A read frame (start 1, opcode 10, address) makes `so` read 0 after the last address bit. Each of the next 16 rising `sclk` edges then presents one bit of the word, bit 15 first.
- R2: The address field is ADDR_W bits wide and is taken most significant bit first. Words 0 and 2^ADDR_W-1 are reached independently.
- R3: A write (opcode 01), erase (opcode 11), erase-all or write-all leaves every word unchanged unless programming is enabled.
- R4: Opcode 00 with top address bits 11 enables programming. Opcode 00 with top address bits 00 disables it again. The low address bits are don't-care.
- R5: A write takes 16 data bits, MSB first, after the address and stores them at the addressed word.
- R6: An enabled erase sets the addressed word to 0xFFFF.
- R7: Opcode 00 with top address bits 10, when enabled, sets every word to 0xFFFF.
- R8: Opcode 00 with top address bits 01, when enabled, takes 16 data bits and stores them in every word.
- R9: After an accepted programming frame, raising `cs` before any new start bit makes `so` read 0 while the internal operation runs. `so` reads 1 once PROG_CLKS system clocks have passed.
- R10: A frame sent while the internal operation runs is ignored.
- R11: Dropping `cs` before a frame is complete discards that frame. The decoder then waits for a new start bit.
- R12: After reset, `so` is 0, every word reads 0xFFFF, and programming is disabled. `so` is 0 whenever `cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select, active high |
| sclk | input | 1 | Serial clock, acted on at its rising edge |
| si | input | 1 | Serial data into the device |
| so | output | 1 | Serial data out: read bits or ready status |

## Verification
The bench builds the block with ADDR_W = 6, which gives a 64-word array, and with PROG_CLKS = 200. That busy window is long enough to clock a complete write frame into the device while it is still busy, which brings R10 within reach. It also makes the 0-then-1 status sequence of R9 observable over many cycles. With this width, the address boundaries 0 and 63 and the four extended commands are exercised against a word-by-word model held in the bench.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
    CMD_ERAL, CMD_WRAL, CMD_EWEN, CMD_EWDS
  } cmd_e;

  typedef enum logic [1:0] {ARR_IDLE, ARR_ONE, ARR_ALL} arr_op_e;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_DONE} dec_st_e;
endpackage

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CLKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(PROG_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)               cnt_d = CW'(PROG_CLKS);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  arr_op_e           op,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              word_en;

    assign word_en = (op == ARR_ALL) || ((op == ARR_ONE) && (waddr == ADDR_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '1;
      else if (word_en) word_q <= wdata;
    end

    assign words[g] = word_q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/mw_frame_dec.sv
module mw_frame_dec
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sclk,
  input  logic              si,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit,
  output logic              idle,
  output logic              frame_start,
  output logic              exec,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] data
);
  localparam int HDR_LEN = ADDR_W + 2;
  localparam int CNT_W   = $clog2(WORD_W + HDR_LEN + 1);

  dec_st_e            st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [HDR_LEN-1:0] hdr_q, hdr_d, hdr_nx;
  logic [WORD_W-1:0]  dat_q, dat_d, rsh_q, rsh_d;
  logic               rbit_q, rbit_d;
  cmd_e               cmd_q, cmd_d;
  logic               sclk_q, cs_q;
  logic               sclk_rise, cs_fall;
  logic [1:0]         opc, ext;
  cmd_e               dec_cmd;

  assign sclk_rise = sclk & ~sclk_q;
  assign cs_fall   = cs_q & ~cs;
  assign hdr_nx    = {hdr_q[HDR_LEN-2:0], si};
  assign rd_addr   = hdr_nx[ADDR_W-1:0];
  assign opc       = hdr_nx[HDR_LEN-1 -: 2];
  assign ext       = hdr_nx[ADDR_W-1 -: 2];

  always_comb begin
    unique case (opc)
      2'b10:   dec_cmd = CMD_READ;
      2'b01:   dec_cmd = CMD_WRITE;
      2'b11:   dec_cmd = CMD_ERASE;
      default: begin
        unique case (ext)
          2'b11:   dec_cmd = CMD_EWEN;
          2'b10:   dec_cmd = CMD_ERAL;
          2'b01:   dec_cmd = CMD_WRAL;
          default: dec_cmd = CMD_EWDS;
        endcase
      end
    endcase
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hdr_d  = hdr_q;
    dat_d  = dat_q;
    rsh_d  = rsh_q;
    rbit_d = rbit_q;
    cmd_d  = cmd_q;
    if (!cs) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      rbit_d = 1'b0;
    end else if (sclk_rise) begin
      unique case (st_q)
        ST_IDLE: if (si && !busy) begin
          st_d  = ST_HDR;
          cnt_d = '0;
        end
        ST_HDR: begin
          hdr_d = hdr_nx;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_LEN - 1)) begin
            cnt_d = '0;
            cmd_d = dec_cmd;
            if (dec_cmd == CMD_READ) begin
              st_d   = ST_READ;
              rsh_d  = rd_word;
              rbit_d = 1'b0;
            end else if (dec_cmd == CMD_WRITE || dec_cmd == CMD_WRAL) begin
              st_d = ST_DATA;
            end else begin
              st_d = ST_DONE;
            end
          end
        end
        ST_DATA: begin
          dat_d = {dat_q[WORD_W-2:0], si};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(WORD_W - 1)) st_d = ST_DONE;
        end
        ST_READ: begin
          if (cnt_q < CNT_W'(WORD_W)) begin
            rbit_d = rsh_q[WORD_W-1];
            rsh_d  = {rsh_q[WORD_W-2:0], 1'b0};
            cnt_d  = cnt_q + 1'b1;
          end else begin
            rbit_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hdr_q  <= '0;
      dat_q  <= '0;
      rsh_q  <= '0;
      rbit_q <= 1'b0;
      cmd_q  <= CMD_NONE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hdr_q  <= hdr_d;
      dat_q  <= dat_d;
      rsh_q  <= rsh_d;
      rbit_q <= rbit_d;
      cmd_q  <= cmd_d;
      sclk_q <= sclk;
      cs_q   <= cs;
    end
  end

  assign idle        = (st_q == ST_IDLE);
  assign frame_start = cs && sclk_rise && idle && si && !busy;
  assign exec        = cs_fall && (st_q == ST_DONE);
  assign cmd         = cmd_q;
  assign addr        = hdr_q[ADDR_W-1:0];
  assign data        = dat_q;
  assign rd_bit      = rbit_q;
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PROG_CLKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic si,
  output logic so
);
  logic              busy, rd_bit, dec_idle, frame_start, exec;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr, rd_addr;
  logic [WORD_W-1:0] data, rd_word, arr_val;
  arr_op_e           arr_op;
  logic              is_prog, accept;
  logic              wen_q, wen_d, show_q, show_d;

  mw_frame_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .si(si), .busy(busy),
    .rd_word(rd_word), .rd_addr(rd_addr), .rd_bit(rd_bit), .idle(dec_idle),
    .frame_start(frame_start), .exec(exec), .cmd(cmd), .addr(addr), .data(data)
  );

  mw_word_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .op(arr_op), .waddr(addr), .wdata(arr_val),
    .raddr(rd_addr), .rdata(rd_word)
  );

  mw_prog_timer #(.PROG_CLKS(PROG_CLKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy)
  );

  always_comb begin
    is_prog = (cmd == CMD_WRITE) || (cmd == CMD_ERASE) ||
              (cmd == CMD_ERAL)  || (cmd == CMD_WRAL);
    accept  = exec && is_prog && wen_q && !busy;
    arr_op  = ARR_IDLE;
    if (accept)
      arr_op = ((cmd == CMD_WRITE) || (cmd == CMD_ERASE)) ? ARR_ONE : ARR_ALL;
    arr_val = ((cmd == CMD_WRITE) || (cmd == CMD_WRAL)) ? data : '1;
    wen_d = wen_q;
    if (exec && cmd == CMD_EWEN) wen_d = 1'b1;
    if (exec && cmd == CMD_EWDS) wen_d = 1'b0;
    show_d = show_q;
    if (frame_start) show_d = 1'b0;
    if (accept)      show_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= 1'b0;
      show_q <= 1'b0;
    end else begin
      wen_q  <= wen_d;
      show_q <= show_d;
    end
  end

  assign so = cs & ((dec_idle & show_q) ? ~busy : rd_bit);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic so,
  input logic busy,
  input logic wen_q,
  input logic accept,
  input logic show_q,
  input logic dec_idle
);
  p_prog_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> wen_q);

  p_status_busy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && show_q && dec_idle && busy) |-> !so);

  p_busy_from_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));

  p_busy_holds_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dec_idle) |=> dec_idle);

  p_quiet_deselected_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !$past(cs)) |-> !so);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .so(so), .busy(busy), .wen_q(wen_q),
  .accept(accept), .show_q(show_q), .dec_idle(dec_idle)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int PROG  = 200;
  localparam int HALF  = 3;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [16:0] val;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, cs, sclk, si;
  logic so;
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 0;
  logic [15:0] model [DEPTH];
  item_t exp_q[$];
  logic [16:0] obs_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.ADDR_W(AW), .PROG_CLKS(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .si(si), .so(so)
  );

  function automatic void check(bit ok, string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // monitor: pops observed read frames and compares with the driver's expectations
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        item_t e;
        logic [16:0] o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        check(o === e.val, e.req, o, e.val);
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(logic b);
    si = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic sel_on();
    cs = 1'b1;
    wait_clk(2);
  endtask

  task automatic sel_off();
    cs = 1'b0; si = 1'b0;
    wait_clk(2);
  endtask

  task automatic send_hdr(logic [1:0] op, logic [AW-1:0] a);
    clk_bit(1'b1);
    clk_bit(op[1]);
    clk_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) clk_bit(a[i]);
  endtask

  task automatic send_word(logic [15:0] d);
    for (int i = 15; i >= 0; i--) clk_bit(d[i]);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    logic [16:0] got;
    item_t it;
    it.val = {1'b0, model[a]};
    it.req = req;
    exp_q.push_back(it);
    sel_on();
    send_hdr(2'b10, a);
    got[16] = so;
    for (int i = 15; i >= 0; i--) begin
      si = 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      got[i] = so;
      sclk = 1'b0;
    end
    obs_q.push_back(got);
    sel_off();
  endtask

  task automatic wait_ready(string req);
    int n;
    bit seen;
    sel_on();
    check(so === 1'b0, req, {16'h0, so}, 17'h0);
    seen = 0;
    n = 0;
    while (!seen && n < PROG + 20) begin
      @(negedge clk);
      n++;
      if (so === 1'b1) seen = 1;
    end
    check(seen, req, {16'h0, seen}, 17'h1);
    sel_off();
  endtask

  task automatic ext_cmd(logic [1:0] sel);
    sel_on();
    send_hdr(2'b00, {sel, {(AW-2){1'b0}}} | AW'(5));
    sel_off();
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d);
    sel_on();
    send_hdr(2'b01, a);
    send_word(d);
    sel_off();
  endtask

  initial begin
    rst_n = 1'b0; cs = 1'b0; sclk = 1'b0; si = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R12: reset state
    check(so === 1'b0, "R12 so after reset", {16'h0, so}, 17'h0);
    do_read(6'd5, "R12 erased after reset");

    // R3: write refused while programming is disabled
    do_write(6'd3, 16'h1234);
    wait_clk(PROG + 10);
    do_read(6'd3, "R3 write ignored when disabled");

    // R4 enable, R5 write, R9 status, R1/R2 read order
    ext_cmd(2'b11);
    do_write(6'd3, 16'hA55A);
    model[3] = 16'hA55A;
    wait_ready("R9 busy then ready after write");
    do_read(6'd3, "R5 R1 write then read back");
    do_write(6'd63, 16'h8001);
    model[63] = 16'h8001;
    wait_ready("R9 ready after write to top");
    do_read(6'd63, "R2 top address");
    do_read(6'd0, "R2 bottom address untouched");

    // R10: frame during busy is ignored
    do_write(6'd10, 16'h1111);
    model[10] = 16'h1111;
    do_write(6'd20, 16'h2222);
    wait_ready("R10 status after busy-time frame");
    do_read(6'd20, "R10 frame during busy ignored");
    do_read(6'd10, "R5 write before busy frame");

    // R6: erase one word
    sel_on();
    send_hdr(2'b11, 6'd3);
    sel_off();
    model[3] = 16'hFFFF;
    wait_ready("R9 ready after erase");
    do_read(6'd3, "R6 erase");

    // R11: aborted write
    sel_on();
    send_hdr(2'b01, 6'd7);
    for (int i = 0; i < 8; i++) clk_bit(1'b0);
    sel_off();
    wait_clk(PROG + 10);
    do_read(6'd7, "R11 aborted frame discarded");

    // R8: write-all
    sel_on();
    send_hdr(2'b00, 6'b010000);
    send_word(16'h0F0F);
    sel_off();
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h0F0F;
    wait_ready("R9 ready after write-all");
    do_read(6'd0, "R8 write-all word 0");
    do_read(6'd33, "R8 write-all word 33");
    do_read(6'd63, "R8 write-all word 63");

    // R7: erase-all
    ext_cmd(2'b10);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    wait_ready("R9 ready after erase-all");
    do_read(6'd0, "R7 erase-all word 0");
    do_read(6'd63, "R7 erase-all word 63");

    // R4: disable, then write is refused
    ext_cmd(2'b00);
    do_write(6'd5, 16'h0000);
    wait_clk(PROG + 10);
    do_read(6'd5, "R4 write refused after disable");
    check(so === 1'b0, "R12 so low while deselected", {16'h0, so}, 17'h0);

    wait_clk(5);
    check(exp_q.size() == 0, "scoreboard drained", 17'(exp_q.size()), 17'h0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule